// File: doc/BRIEF.md
# Multi-Channel Input Capture Unit

This block timestamps edges on three independent input lines against one shared 32-bit free-running timer. Each line is brought into the clock domain through a two-flop synchronizer, optionally inverted, and then watched for a selected edge type (rising, falling, both or none). A per-channel divider lets only every Nth qualifying edge produce a capture, with N from 1 to 256. On a capture the channel latches the timer value, notes whether the edge was rising or falling, and pulses its interrupt line for one clock. Software can force a capture on any channel at any time.

The timer counts up by one per clock while enabled. It can be realigned to a programmable phase by a sync event from a PWM timer pulse, a software strobe, or a rising edge on an asynchronous external sync pin. The captured results flow out as held registers. The one-cycle interrupt pulse acts as a valid strobe without a ready. There is no back-pressure: a result stays in place until the next capture on that channel overwrites it, so a consumer must read it before then.

Top module: `cap_unit`

## Requirements
- R1: After reset `tmr_q` is 0. It increments by 1 on every clock edge while `tmr_en` is 1 and holds its value while `tmr_en` is 0, when no sync event is present.
- R2: A one-cycle pulse on `sync_pwm` or `sync_sw` loads `tmr_phase` into `tmr_q` at the next clock edge, whatever `tmr_en` is. The load takes priority over counting.
- R3: `sync_ext` is asynchronous and passes through a two-flop synchronizer. Its rising edge causes exactly one phase load, visible on `tmr_q` after the third clock edge that samples it high. Holding the pin high causes no further loads.
- R4: Each channel XORs its synchronized input with `ch_inv[i]` before edge detection. The 2-bit field `ch_mode[2i+1:2i]` selects the edges: bit 0 selects rising edges and bit 1 selects falling edges of the post-inversion signal, so 00 selects none and 11 selects both.
- R5: With divider field `ch_div[8i+7:8i]` = P, a capture occurs on every (P+1)-th qualifying edge, covering factors 1 to 256. The edge count restarts from zero whenever the channel is disabled.
- R6: On a capture, `ch_irq[i]` is high for exactly one cycle. In the same clock edge `ch_stamp[32i+31:32i]` takes the value that `tmr_q` held in the cycle before. An input change sampled at clock edge k produces the capture at edge k+2.
- R7: `ch_fall[i]` records the edge that caused the most recent edge capture: 0 for rising and 1 for falling, both of the post-inversion signal.
- R8: A one-cycle `ch_force[i]` pulse causes a capture at the next edge, even on a disabled channel. It leaves `ch_fall[i]` and the divider count unchanged.
- R9: When a force and a divider-completing edge fall in the same cycle, one capture and one interrupt pulse result, `ch_fall[i]` is updated, and the divider restarts.
- R10: A channel with `ch_en[i]` = 0 never captures on edges. Its interrupt stays low and its timestamp is unchanged.
- R11: When a capture and a timer load happen in the same cycle, the timestamp holds the timer value from before the load.
- R12: Force, configuration and input activity on one channel have no effect on the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_en | input | 1 | Timer count enable |
| tmr_phase | input | 32 | Value loaded into the timer on a sync event |
| sync_pwm | input | 1 | Sync pulse from a PWM timer (synchronous) |
| sync_ext | input | 1 | External sync pin (asynchronous, rising edge) |
| sync_sw | input | 1 | Software sync strobe (synchronous) |
| tmr_q | output | 32 | Current timer value |
| ch_en | input | 3 | Per-channel enable |
| cap_in | input | 3 | Asynchronous capture inputs |
| ch_inv | input | 3 | Per-channel input inversion |
| ch_mode | input | 6 | Per-channel edge select, 2 bits each |
| ch_div | input | 24 | Per-channel divider field (factor minus one), 8 bits each |
| ch_force | input | 3 | Per-channel software capture strobe |
| ch_stamp | output | 96 | Per-channel timestamps, 32 bits each |
| ch_fall | output | 3 | Edge of the last edge capture, 1 = falling |
| ch_irq | output | 3 | One-cycle capture pulse per channel |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a forced capture and a divider-completing edge on one channel. The force is raised exactly two edges after the input change is driven, so both reach the capture register together. The bench then requires a single interrupt pulse, an updated edge flag and a restarted divider. The second pair is a capture and a timer sync load. A force and a software sync are driven in the same cycle, and the timestamp must hold the pre-load timer value while the timer shows the phase.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int unsigned CAP_TW   = 32;
  localparam int unsigned CAP_NCH  = 3;
  localparam int unsigned CAP_DIVW = 8;

  // Edge selection field of one channel
  typedef enum logic [1:0] {
    EDG_NONE = 2'b00,
    EDG_RISE = 2'b01,
    EDG_FALL = 2'b10,
    EDG_BOTH = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_hit_t;
endpackage

// File: rtl/cap_sync2.sv
module cap_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cap_timer.sv
module cap_timer #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic [TW-1:0] phase,
  output logic [TW-1:0] cnt
);
  localparam logic [TW-1:0] STEP = {{(TW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= phase;
    else if (en)
      cnt <= cnt + STEP;
  end
endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_pkg::*;
#(
  parameter int TW   = 32,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            lvl_in,
  input  logic            inv,
  input  logic [1:0]      mode,
  input  logic [DIVW-1:0] div,
  input  logic            force_cap,
  input  logic [TW-1:0]   tmr,
  output logic [TW-1:0]   stamp,
  output logic            fall_q,
  output logic            irq
);
  localparam logic [DIVW-1:0] ONE = {{(DIVW-1){1'b0}}, 1'b1};

  logic            lvl;
  logic            lvl_q;
  edge_hit_t       eh;
  edge_sel_e       sel;
  logic            qual;
  logic            hit;
  logic [DIVW-1:0] pcnt;

  assign lvl = lvl_in ^ inv;
  assign sel = edge_sel_e'(mode);

  always_comb begin
    eh.rise = lvl & ~lvl_q;
    eh.fall = ~lvl & lvl_q;
    unique case (sel)
      EDG_NONE: qual = 1'b0;
      EDG_RISE: qual = eh.rise;
      EDG_FALL: qual = eh.fall;
      EDG_BOTH: qual = eh.rise | eh.fall;
      default:  qual = 1'b0;
    endcase
    qual = qual & en;
    hit  = qual && (pcnt == div);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      pcnt   <= '0;
      stamp  <= '0;
      fall_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      lvl_q <= lvl;
      if (!en)
        pcnt <= '0;
      else if (qual)
        pcnt <= hit ? '0 : pcnt + ONE;
      irq <= hit | force_cap;
      if (hit | force_cap)
        stamp <= tmr;
      if (hit)
        fall_q <= eh.fall;
    end
  end
endmodule

// File: rtl/cap_unit.sv
module cap_unit
  import cap_pkg::*;
#(
  parameter int TW   = CAP_TW,
  parameter int NCH  = CAP_NCH,
  parameter int DIVW = CAP_DIVW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_en,
  input  logic [TW-1:0]     tmr_phase,
  input  logic              sync_pwm,
  input  logic              sync_ext,
  input  logic              sync_sw,
  output logic [TW-1:0]     tmr_q,
  input  logic [NCH-1:0]    ch_en,
  input  logic [NCH-1:0]    cap_in,
  input  logic [NCH-1:0]    ch_inv,
  input  logic [2*NCH-1:0]  ch_mode,
  input  logic [DIVW*NCH-1:0] ch_div,
  input  logic [NCH-1:0]    ch_force,
  output logic [TW*NCH-1:0] ch_stamp,
  output logic [NCH-1:0]    ch_fall,
  output logic [NCH-1:0]    ch_irq
);
  logic [NCH-1:0] cap_s;
  logic           ext_s;
  logic           ext_q;
  logic           ext_hit;
  logic           sync_evt;

  cap_sync2 #(.W(NCH)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .d(cap_in), .q(cap_s)
  );

  cap_sync2 #(.W(1)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d(sync_ext), .q(ext_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_s;
  end

  assign ext_hit  = ext_s & ~ext_q;
  assign sync_evt = sync_pwm | sync_sw | ext_hit;

  cap_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(tmr_en), .load(sync_evt),
    .phase(tmr_phase), .cnt(tmr_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cap_channel #(.TW(TW), .DIVW(DIVW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ch_en[i]),
      .lvl_in   (cap_s[i]),
      .inv      (ch_inv[i]),
      .mode     (ch_mode[2*i +: 2]),
      .div      (ch_div[DIVW*i +: DIVW]),
      .force_cap(ch_force[i]),
      .tmr      (tmr_q),
      .stamp    (ch_stamp[TW*i +: TW]),
      .fall_q   (ch_fall[i]),
      .irq      (ch_irq[i])
    );
  end
endmodule

// File: rtl/cap_unit_chk.sv
module cap_unit_chk #(
  parameter int TW  = 32,
  parameter int NCH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tmr_en,
  input logic              sync_evt,
  input logic [TW-1:0]     tmr_phase,
  input logic [TW-1:0]     tmr_q,
  input logic [NCH-1:0]    ch_en,
  input logic [NCH-1:0]    ch_force,
  input logic [TW*NCH-1:0] ch_stamp,
  input logic [NCH-1:0]    ch_irq
);
  localparam logic [TW-1:0] ONE = {{(TW-1){1'b0}}, 1'b1};

  p_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_en && !sync_evt) |=> (tmr_q == $past(tmr_q) + ONE));

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_en && !sync_evt) |=> $stable(tmr_q));

  p_sync_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> (tmr_q == $past(tmr_phase)));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_stamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ch_irq[i] |-> (ch_stamp[TW*i +: TW] == $past(tmr_q)));

    p_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ch_force[i] |=> ch_irq[i]);

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_en[i] && !ch_force[i]) |=> !ch_irq[i]);
  end
endmodule

bind cap_unit cap_unit_chk #(.TW(TW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .sync_evt(sync_evt),
  .tmr_phase(tmr_phase), .tmr_q(tmr_q), .ch_en(ch_en),
  .ch_force(ch_force), .ch_stamp(ch_stamp), .ch_irq(ch_irq)
);

// File: tb/cap_unit_bench.sv
module cap_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr_en = 1'b0;
  logic [31:0] tmr_phase = '0;
  logic        sync_pwm = 1'b0;
  logic        sync_ext = 1'b0;
  logic        sync_sw = 1'b0;
  logic [31:0] tmr_q;
  logic [2:0]  ch_en = '0;
  logic [2:0]  cap_in = '0;
  logic [2:0]  ch_inv = '0;
  logic [5:0]  ch_mode = '0;
  logic [23:0] ch_div = '0;
  logic [2:0]  ch_force = '0;
  logic [95:0] ch_stamp;
  logic [2:0]  ch_fall;
  logic [2:0]  ch_irq;

  int nchk = 0;
  int nerr = 0;
  int cnt [3] = '{0, 0, 0};
  logic [31:0] prev_tmr = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cap_unit u_cap_unit (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .tmr_phase(tmr_phase),
    .sync_pwm(sync_pwm), .sync_ext(sync_ext), .sync_sw(sync_sw),
    .tmr_q(tmr_q), .ch_en(ch_en), .cap_in(cap_in), .ch_inv(ch_inv),
    .ch_mode(ch_mode), .ch_div(ch_div), .ch_force(ch_force),
    .ch_stamp(ch_stamp), .ch_fall(ch_fall), .ch_irq(ch_irq)
  );

  // {inv, mode[1:0], div[7:0], pulses[8:0], captures[8:0], fall}
  localparam logic [29:0] VEC [0:7] = '{
    {1'b0, 2'b01, 8'd0, 9'd3, 9'd3, 1'b0},
    {1'b0, 2'b10, 8'd0, 9'd3, 9'd3, 1'b1},
    {1'b1, 2'b01, 8'd0, 9'd2, 9'd2, 1'b0},
    {1'b0, 2'b11, 8'd0, 9'd2, 9'd4, 1'b1},
    {1'b0, 2'b01, 8'd2, 9'd7, 9'd2, 1'b0},
    {1'b1, 2'b11, 8'd1, 9'd3, 9'd3, 1'b0},
    {1'b0, 2'b00, 8'd0, 9'd3, 9'd0, 1'b0},
    {1'b1, 2'b10, 8'd0, 9'd2, 9'd2, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int ch, input int n);
    for (int k = 0; k < n; k++) begin
      cap_in[ch] = 1'b1;
      ticks(4);
      cap_in[ch] = 1'b0;
      ticks(4);
    end
    ticks(4);
  endtask

  // Capture monitor: counts interrupt pulses, checks timestamps (R6, R11)
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      for (int i = 0; i < 3; i++) begin
        if (ch_irq[i]) begin
          cnt[i]++;
          chk(ch_stamp[32*i +: 32] == prev_tmr, "R6 timestamp",
              ch_stamp[32*i +: 32], prev_tmr);
        end
      end
    end
    prev_tmr = tmr_q;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    summary();
  end

  initial begin
    logic [31:0] t0;
    int c0, c1, c2;
    ticks(3);
    // Reset state
    chk(tmr_q == 32'd0, "R1 reset timer", tmr_q, 32'd0);
    chk(ch_irq == 3'b000, "R6 reset irq", 32'(ch_irq), 32'd0);
    chk(ch_stamp == '0, "R6 reset stamp", ch_stamp[31:0], 32'd0);
    rst_n = 1'b1;
    ticks(5);
    chk(tmr_q == 32'd0, "R1 hold while disabled", tmr_q, 32'd0);

    // R1 counting
    tmr_en = 1'b1;
    ticks(1);
    t0 = tmr_q;
    ticks(10);
    chk(tmr_q == t0 + 32'd10, "R1 count", tmr_q, t0 + 32'd10);

    // R2 PWM sync while counting
    tmr_phase = 32'h1000_0000;
    sync_pwm = 1'b1;
    ticks(1);
    sync_pwm = 1'b0;
    chk(tmr_q == 32'h1000_0000, "R2 pwm sync load", tmr_q, 32'h1000_0000);
    ticks(1);
    chk(tmr_q == 32'h1000_0001, "R2 count after load", tmr_q, 32'h1000_0001);

    // R2 software sync while disabled
    tmr_en = 1'b0;
    tmr_phase = 32'h2222_0000;
    sync_sw = 1'b1;
    ticks(1);
    sync_sw = 1'b0;
    ticks(2);
    chk(tmr_q == 32'h2222_0000, "R2 sw sync load", tmr_q, 32'h2222_0000);

    // R3 external sync latency and single load
    tmr_phase = 32'h3333_0000;
    sync_ext = 1'b1;
    ticks(2);
    chk(tmr_q == 32'h2222_0000, "R3 ext not yet loaded", tmr_q, 32'h2222_0000);
    ticks(1);
    chk(tmr_q == 32'h3333_0000, "R3 ext loaded", tmr_q, 32'h3333_0000);
    tmr_phase = 32'h4444_0000;
    ticks(5);
    chk(tmr_q == 32'h3333_0000, "R3 ext held high no reload", tmr_q, 32'h3333_0000);
    sync_ext = 1'b0;
    ticks(4);
    tmr_en = 1'b1;

    // Vector table on channel 0 (R4, R5, R7)
    for (int v = 0; v < 8; v++) begin
      ch_en[0] = 1'b0;
      ch_inv[0] = VEC[v][29];
      ch_mode[1:0] = VEC[v][28:27];
      ch_div[7:0] = VEC[v][26:19];
      ticks(4);
      ch_en[0] = 1'b1;
      ticks(2);
      c0 = cnt[0];
      pulses(0, int'(VEC[v][18:10]));
      chk(cnt[0] - c0 == int'(VEC[v][9:1]), "R4 R5 vector captures",
          32'(cnt[0] - c0), 32'(VEC[v][9:1]));
      chk(ch_fall[0] == VEC[v][0], "R7 vector edge flag",
          32'(ch_fall[0]), 32'(VEC[v][0]));
    end

    // R5 largest divider: 256 edges per capture
    ch_en[0] = 1'b0;
    ch_inv[0] = 1'b0;
    ch_mode[1:0] = 2'b01;
    ch_div[7:0] = 8'd255;
    ticks(4);
    ch_en[0] = 1'b1;
    ticks(2);
    c0 = cnt[0];
    pulses(0, 255);
    chk(cnt[0] == c0, "R5 div 256 before last edge", 32'(cnt[0] - c0), 32'd0);
    pulses(0, 1);
    chk(cnt[0] == c0 + 1, "R5 div 256 at last edge", 32'(cnt[0] - c0), 32'd1);

    // R10 disabled channel ignores edges
    ch_en[0] = 1'b0;
    ch_div[7:0] = 8'd0;
    ticks(2);
    c0 = cnt[0];
    t0 = ch_stamp[31:0];
    pulses(0, 3);
    chk(cnt[0] == c0, "R10 no capture when disabled", 32'(cnt[0] - c0), 32'd0);
    chk(ch_stamp[31:0] == t0, "R10 stamp unchanged", ch_stamp[31:0], t0);

    // R8 force keeps divider count
    ch_div[7:0] = 8'd2;
    ticks(2);
    ch_en[0] = 1'b1;
    ticks(2);
    c0 = cnt[0];
    pulses(0, 2);
    ch_force[0] = 1'b1;
    ticks(1);
    ch_force[0] = 1'b0;
    ticks(2);
    chk(cnt[0] == c0 + 1, "R8 force capture", 32'(cnt[0] - c0), 32'd1);
    pulses(0, 1);
    chk(cnt[0] == c0 + 2, "R8 divider count kept", 32'(cnt[0] - c0), 32'd2);

    // R8 force leaves edge flag; R12 other channels untouched
    ch_en[1] = 1'b1;
    ch_mode[3:2] = 2'b10;
    ch_div[15:8] = 8'd0;
    ticks(2);
    pulses(1, 1);
    chk(ch_fall[1] == 1'b1, "R7 falling edge flag", 32'(ch_fall[1]), 32'd1);
    c0 = cnt[0];
    c1 = cnt[1];
    c2 = cnt[2];
    ch_force[1] = 1'b1;
    ticks(1);
    ch_force[1] = 1'b0;
    ticks(2);
    chk(cnt[1] == c1 + 1, "R8 force ch1", 32'(cnt[1] - c1), 32'd1);
    chk(ch_fall[1] == 1'b1, "R8 force keeps edge flag", 32'(ch_fall[1]), 32'd1);
    chk(cnt[0] == c0 && cnt[2] == c2, "R12 other channels quiet",
        32'(cnt[0] + cnt[2] - c0 - c2), 32'd0);

    // R8 force on a disabled channel
    c2 = cnt[2];
    ch_force[2] = 1'b1;
    ticks(1);
    ch_force[2] = 1'b0;
    ticks(2);
    chk(cnt[2] == c2 + 1, "R8 force on disabled channel", 32'(cnt[2] - c2), 32'd1);

    // R9 force and completing edge in the same cycle
    ch_en[0] = 1'b0;
    ch_mode[1:0] = 2'b01;
    ch_div[7:0] = 8'd0;
    ticks(4);
    ch_en[0] = 1'b1;
    ticks(2);
    c0 = cnt[0];
    cap_in[0] = 1'b1;
    ticks(2);
    ch_force[0] = 1'b1;
    ticks(1);
    ch_force[0] = 1'b0;
    ticks(4);
    cap_in[0] = 1'b0;
    ticks(6);
    chk(cnt[0] == c0 + 1, "R9 single capture", 32'(cnt[0] - c0), 32'd1);
    chk(ch_fall[0] == 1'b0, "R9 edge flag updated", 32'(ch_fall[0]), 32'd0);
    pulses(0, 1);
    chk(cnt[0] == c0 + 2, "R9 divider restarted", 32'(cnt[0] - c0), 32'd2);

    // R11 capture and sync in the same cycle
    tmr_phase = 32'h5555_0000;
    t0 = tmr_q;
    ch_force[2] = 1'b1;
    sync_sw = 1'b1;
    ticks(1);
    ch_force[2] = 1'b0;
    sync_sw = 1'b0;
    chk(ch_stamp[95:64] == t0, "R11 stamp pre-load value", ch_stamp[95:64], t0);
    chk(tmr_q == 32'h5555_0000, "R11 timer loaded", tmr_q, 32'h5555_0000);

    ticks(4);
    summary();
  end
endmodule